// File: doc/BRIEF.md
# Message Buffer Lock Controller

This block decides which message buffers the host may reach at a given moment in a communication controller. Every buffer index belongs to one of three classes: transmit, receive, or receive-FIFO. A successful lock maps the chosen buffer onto the access window for its class, and the three windows are independent. The host issues register writes that carry a buffer index, a lock bit, a commit bit and an error-clear bit. It can read back whether any index is currently locked. The protocol engine tells the block which buffers it is using at that moment.

Each class can hold one lock at a time. Writing 1 to the lock bit of a free buffer asks for a lock. Writing 1 to the lock bit of a buffer that is already locked releases it, and a release takes effect at once. A lock request that cannot be granted leaves all state unchanged and sets a sticky error flag. The host then reads back the lock status and retries if the status is 0.

The receive-FIFO class always works on its current head entry. Releasing that entry moves the read pointer on by one. Controller halves of double transmit buffers, shadow buffers and unused indices can never be locked. Commit marks transmit buffers that are ready for sending, and it is tracked separately from locking.

Top module: `lbc_lock_ctrl`

## Requirements
- R1: After synchronous reset, every class is unlocked, all window enables are 0, the FIFO pointer is 0 (so `fifo_win_idx` = FIFO base = 8), `lock_err` is 0 and `commit_pend` is all 0.
- R2: With the default index map, indices 0–3 are transmit, 4–7 are receive, 8–11 are the FIFO region, and 12–15 map to no buffer. A lock write (`host_wr`=1, `host_lock`=1) to a lockable, idle buffer whose class is free is granted on the next clock edge. The class window enable then reads 1 and the window index equals the buffer. One cycle later, `rd_locked` reads 1 for that index.
- R3: A lock write to a different buffer of a class that already holds a lock fails. It sets `lock_err`, the held lock and its window index stay unchanged, and `rd_locked` reads 0 for the refused index.
- R4: One transmit, one receive and one FIFO lock can be held at the same time, each on its own window.
- R5: A lock write to the buffer that is currently locked releases it on the next edge, with no error and no retry.
- R6: A lock write to any index in the FIFO region targets the entry at the read pointer (index 8 + pointer). Releasing the FIFO lock advances the pointer modulo the FIFO depth.
- R7: A lock write to the controller half of a double transmit buffer (default index 3), to a shadow buffer (default index 7), or to an index with no buffer fails with `lock_err` set and no lock change.
- R8: A lock write whose target buffer has its `pe_busy` bit set fails with `lock_err` set, and the class stays free.
- R9: `lock_err` stays at 1 until a host write with `host_err_clr`=1. A new error in that same write keeps it at 1.
- R10: A host write with `host_commit`=1 to a lockable transmit buffer sets its `commit_pend` bit. The bit survives any number of lock and release cycles and is cleared by `pe_sent`. If a commit and `pe_sent` arrive in the same cycle, the commit wins. A commit to any other index has no effect.
- R11: A host write with `host_lock`=0 changes no lock, window or FIFO pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_idx | input | IDX_W | Buffer index of the write |
| host_lock | input | 1 | Lock bit: 1 requests a lock, or releases a held buffer |
| host_commit | input | 1 | Commit bit for transmit buffers |
| host_err_clr | input | 1 | Writing 1 clears the sticky error |
| rd_idx | input | IDX_W | Index whose lock status is read back |
| rd_locked | output | 1 | Registered lock status of `rd_idx` |
| pe_busy | input | NUM_BUF | Per-buffer busy marks from the protocol engine |
| pe_sent | input | NUM_TX | Per-transmit-buffer sent pulses, clearing commit |
| tx_win_en | output | 1 | Transmit window active |
| tx_win_idx | output | IDX_W | Buffer mapped to the transmit window |
| rx_win_en | output | 1 | Receive window active |
| rx_win_idx | output | IDX_W | Buffer mapped to the receive window |
| fifo_win_en | output | 1 | FIFO window active |
| fifo_win_idx | output | IDX_W | Current FIFO head entry |
| lock_err | output | 1 | Sticky lock error flag |
| commit_pend | output | NUM_TX | Committed transmit buffers awaiting send |

## Verification
All window enables and window indices come straight from the class registers. A corrupted lock state therefore appears at the ports on the clock edge after the write that caused it. The lock readback lags by one more cycle, because it is registered. A pointer fault in the FIFO shows in `fifo_win_idx` at once and stays there, so each later FIFO lock reveals it. Because the error flag is sticky, a missed error can hide behind an earlier one. The sweeps therefore clear the flag after every failure, so each refusal is seen on its own.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic [1:0] {
    CLS_TX   = 2'd0,
    CLS_RX   = 2'd1,
    CLS_FIFO = 2'd2,
    CLS_NONE = 2'd3
  } buf_class_e;

  localparam int NUM_CLASSES = 3;
endpackage

// File: rtl/lbc_decode.sv
module lbc_decode
  import lbc_pkg::*;
#(
  parameter int NUM_TX = 4,
  parameter int NUM_RX = 4,
  parameter int NUM_BUF = 12,
  parameter int IDX_W = 4,
  parameter logic [NUM_BUF-1:0] CC_HALF_MASK = '0,
  parameter logic [NUM_BUF-1:0] SHADOW_MASK = '0
) (
  input  logic [IDX_W-1:0] idx,
  output buf_class_e       cls,
  output logic             lockable,
  output logic             commit_ok
);
  localparam int RX_BASE   = NUM_TX;
  localparam int FIFO_BASE = NUM_TX + NUM_RX;
  localparam int PAD       = 1 << IDX_W;
  localparam logic [PAD-1:0] CC_PAD = PAD'(CC_HALF_MASK);
  localparam logic [PAD-1:0] SH_PAD = PAD'(SHADOW_MASK);

  always_comb begin
    if (int'(idx) < RX_BASE)        cls = CLS_TX;
    else if (int'(idx) < FIFO_BASE) cls = CLS_RX;
    else if (int'(idx) < NUM_BUF)   cls = CLS_FIFO;
    else                            cls = CLS_NONE;
    lockable  = (cls != CLS_NONE) && !CC_PAD[idx] && !SH_PAD[idx];
    commit_ok = (cls == CLS_TX) && lockable;
  end
endmodule

// File: rtl/lbc_slot.sv
module lbc_slot #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic             tgt_busy,
  output logic             held,
  output logic [IDX_W-1:0] held_idx,
  output logic             fail
);
  logic grant, rel;

  always_comb begin
    rel   = req && held && (held_idx == tgt_idx);
    grant = req && !held && !tgt_busy;
    fail  = req && ((held && (held_idx != tgt_idx)) || (!held && tgt_busy));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= 1'b0;
      held_idx <= '0;
    end else if (grant) begin
      held     <= 1'b1;
      held_idx <= tgt_idx;
    end else if (rel) begin
      held     <= 1'b0;
    end
  end
endmodule

// File: rtl/lbc_fifo_ptr.sv
module lbc_fifo_ptr #(
  parameter int DEPTH = 4,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/lbc_lock_ctrl.sv
module lbc_lock_ctrl
  import lbc_pkg::*;
#(
  parameter int NUM_TX = 4,
  parameter int NUM_RX = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int NUM_BUF = NUM_TX + NUM_RX + FIFO_DEPTH,
  parameter int IDX_W = $clog2(NUM_BUF),
  parameter logic [NUM_BUF-1:0] CC_HALF_MASK = 'h008,
  parameter logic [NUM_BUF-1:0] SHADOW_MASK = 'h080
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic [IDX_W-1:0]   host_idx,
  input  logic               host_lock,
  input  logic               host_commit,
  input  logic               host_err_clr,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_locked,
  input  logic [NUM_BUF-1:0] pe_busy,
  input  logic [NUM_TX-1:0]  pe_sent,
  output logic               tx_win_en,
  output logic [IDX_W-1:0]   tx_win_idx,
  output logic               rx_win_en,
  output logic [IDX_W-1:0]   rx_win_idx,
  output logic               fifo_win_en,
  output logic [IDX_W-1:0]   fifo_win_idx,
  output logic               lock_err,
  output logic [NUM_TX-1:0]  commit_pend
);
  localparam int FIFO_BASE = NUM_TX + NUM_RX;
  localparam int PTR_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int PAD       = 1 << IDX_W;

  buf_class_e       cls;
  logic             lockable, commit_ok, lock_wr, new_err, fifo_adv;
  logic [PTR_W-1:0] fifo_ptr;
  logic [IDX_W-1:0] fifo_tgt;
  logic [PAD-1:0]   busy_pad;

  logic [IDX_W-1:0] slot_tgt  [NUM_CLASSES];
  logic [IDX_W-1:0] slot_idx  [NUM_CLASSES];
  logic             slot_req  [NUM_CLASSES];
  logic             slot_held [NUM_CLASSES];
  logic             slot_fail [NUM_CLASSES];
  logic             slot_busy [NUM_CLASSES];

  lbc_decode #(
    .NUM_TX(NUM_TX), .NUM_RX(NUM_RX), .NUM_BUF(NUM_BUF), .IDX_W(IDX_W),
    .CC_HALF_MASK(CC_HALF_MASK), .SHADOW_MASK(SHADOW_MASK)
  ) dec_i (
    .idx(host_idx), .cls(cls), .lockable(lockable), .commit_ok(commit_ok)
  );

  lbc_fifo_ptr #(.DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) ptr_i (
    .clk(clk), .rst(rst), .adv(fifo_adv), .ptr(fifo_ptr)
  );

  assign lock_wr  = host_wr && host_lock;
  assign busy_pad = PAD'(pe_busy);
  assign fifo_tgt = IDX_W'(FIFO_BASE) + IDX_W'(fifo_ptr);

  genvar c;
  generate
    for (c = 0; c < NUM_CLASSES; c++) begin : g_slot
      assign slot_tgt[c]  = (c == int'(CLS_FIFO)) ? fifo_tgt : host_idx;
      assign slot_req[c]  = lock_wr && lockable && (cls == buf_class_e'(c));
      assign slot_busy[c] = busy_pad[slot_tgt[c]];
      lbc_slot #(.IDX_W(IDX_W)) slot_i (
        .clk(clk), .rst(rst), .req(slot_req[c]), .tgt_idx(slot_tgt[c]),
        .tgt_busy(slot_busy[c]), .held(slot_held[c]),
        .held_idx(slot_idx[c]), .fail(slot_fail[c])
      );
    end
  endgenerate

  // the FIFO slot always targets its head, so a write while held is a release
  assign fifo_adv = slot_req[int'(CLS_FIFO)] && slot_held[int'(CLS_FIFO)];

  assign new_err = lock_wr && (!lockable || slot_fail[0] || slot_fail[1] || slot_fail[2]);

  always_ff @(posedge clk) begin
    if (rst)                           lock_err <= 1'b0;
    else if (new_err)                  lock_err <= 1'b1;
    else if (host_wr && host_err_clr)  lock_err <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_locked <= 1'b0;
    else     rd_locked <= (slot_held[0] && rd_idx == slot_idx[0]) ||
                          (slot_held[1] && rd_idx == slot_idx[1]) ||
                          (slot_held[2] && rd_idx == fifo_tgt);
  end

  genvar t;
  generate
    for (t = 0; t < NUM_TX; t++) begin : g_commit
      always_ff @(posedge clk) begin
        if (rst)
          commit_pend[t] <= 1'b0;
        else if (host_wr && host_commit && commit_ok && host_idx == IDX_W'(t))
          commit_pend[t] <= 1'b1;
        else if (pe_sent[t])
          commit_pend[t] <= 1'b0;
      end
    end
  endgenerate

  assign tx_win_en    = slot_held[int'(CLS_TX)];
  assign tx_win_idx   = slot_idx[int'(CLS_TX)];
  assign rx_win_en    = slot_held[int'(CLS_RX)];
  assign rx_win_idx   = slot_idx[int'(CLS_RX)];
  assign fifo_win_en  = slot_held[int'(CLS_FIFO)];
  assign fifo_win_idx = fifo_tgt;
endmodule

// File: rtl/lbc_lock_ctrl_chk.sv
module lbc_lock_ctrl_chk #(
  parameter int NUM_TX = 4,
  parameter int NUM_RX = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int NUM_BUF = NUM_TX + NUM_RX + FIFO_DEPTH,
  parameter int IDX_W = $clog2(NUM_BUF),
  parameter logic [NUM_BUF-1:0] CC_HALF_MASK = 'h008,
  parameter logic [NUM_BUF-1:0] SHADOW_MASK = 'h080
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr,
  input logic [IDX_W-1:0]   host_idx,
  input logic               host_lock,
  input logic               host_commit,
  input logic               host_err_clr,
  input logic [IDX_W-1:0]   rd_idx,
  input logic               rd_locked,
  input logic [NUM_BUF-1:0] pe_busy,
  input logic [NUM_TX-1:0]  pe_sent,
  input logic               tx_win_en,
  input logic [IDX_W-1:0]   tx_win_idx,
  input logic               rx_win_en,
  input logic [IDX_W-1:0]   rx_win_idx,
  input logic               fifo_win_en,
  input logic [IDX_W-1:0]   fifo_win_idx,
  input logic               lock_err,
  input logic [NUM_TX-1:0]  commit_pend
);
  localparam int FIFO_BASE = NUM_TX + NUM_RX;
  localparam int PAD = 1 << IDX_W;
  localparam logic [PAD-1:0] CC_PAD = PAD'(CC_HALF_MASK);
  localparam logic [PAD-1:0] SH_PAD = PAD'(SHADOW_MASK);
  localparam logic [PAD-1:0] MASKED = CC_PAD | SH_PAD;

  logic [PAD-1:0] busy_pad;
  logic           lk, in_tx, in_rx, in_fifo;
  assign busy_pad = PAD'(pe_busy);
  assign lk       = host_wr && host_lock && !MASKED[host_idx];
  assign in_tx    = int'(host_idx) < NUM_TX;
  assign in_rx    = int'(host_idx) >= NUM_TX && int'(host_idx) < FIFO_BASE;
  assign in_fifo  = int'(host_idx) >= FIFO_BASE && int'(host_idx) < NUM_BUF;

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tx_win_en && !rx_win_en && !fifo_win_en && !lock_err &&
                   commit_pend == '0 && fifo_win_idx == IDX_W'(FIFO_BASE));

  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    $past(tx_win_en && rd_idx == tx_win_idx) |-> rd_locked);

  p_hold_tx_r3: assert property (@(posedge clk) disable iff (rst)
    tx_win_en && host_wr && host_lock && in_tx && host_idx != tx_win_idx
    |=> tx_win_en && $stable(tx_win_idx) && lock_err);

  p_hold_rx_r3: assert property (@(posedge clk) disable iff (rst)
    rx_win_en && host_wr && host_lock && in_rx && host_idx != rx_win_idx
    |=> rx_win_en && $stable(rx_win_idx) && lock_err);

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    lk && tx_win_en && host_idx == tx_win_idx |=> !tx_win_en);

  p_fifo_adv_r6: assert property (@(posedge clk) disable iff (rst)
    lk && fifo_win_en && in_fifo
    |=> !fifo_win_en && (FIFO_DEPTH == 1 || fifo_win_idx != $past(fifo_win_idx)));

  p_no_masked_r7: assert property (@(posedge clk) disable iff (rst)
    tx_win_en |-> !MASKED[tx_win_idx]);

  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    lk && !tx_win_en && in_tx && busy_pad[host_idx] |=> !tx_win_en && lock_err);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    lock_err && !(host_wr && host_err_clr) |=> lock_err);

  p_commit_r10: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_commit && in_tx && !MASKED[host_idx]
    |=> commit_pend[$past(host_idx)]);

  p_sent_r10: assert property (@(posedge clk) disable iff (rst)
    pe_sent[0] && !(host_wr && host_commit && host_idx == '0) |=> !commit_pend[0]);

  p_nolock_r11: assert property (@(posedge clk) disable iff (rst)
    host_wr && !host_lock |=> $stable(tx_win_en) && $stable(rx_win_en) &&
                              $stable(fifo_win_en) && $stable(fifo_win_idx));
endmodule

bind lbc_lock_ctrl lbc_lock_ctrl_chk #(
  .NUM_TX(NUM_TX), .NUM_RX(NUM_RX), .FIFO_DEPTH(FIFO_DEPTH), .NUM_BUF(NUM_BUF),
  .IDX_W(IDX_W), .CC_HALF_MASK(CC_HALF_MASK), .SHADOW_MASK(SHADOW_MASK)
) chk_i (.*);

// File: tb/lbc_lock_ctrl_tb_top.sv
module lbc_lock_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 0, host_lock = 0, host_commit = 0, host_err_clr = 0;
  logic [3:0]  host_idx = '0, rd_idx = '0;
  logic        rd_locked;
  logic [11:0] pe_busy = '0;
  logic [3:0]  pe_sent = '0;
  logic        tx_win_en, rx_win_en, fifo_win_en, lock_err;
  logic [3:0]  tx_win_idx, rx_win_idx, fifo_win_idx, commit_pend;

  always #5 clk = ~clk;

  lbc_lock_ctrl dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit m_tx_h, m_rx_h, m_ff_h, m_err;
  int m_tx_i, m_rx_i, m_ptr;
  bit [3:0] m_cp;

  function automatic bit bad_idx(int i);
    return i >= 12 || i == 3 || i == 7;
  endfunction

  function automatic bit m_locked(int i);
    return (m_tx_h && i == m_tx_i) || (m_rx_h && i == m_rx_i) || (m_ff_h && i == 8 + m_ptr);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, "tx_win_en", tx_win_en, m_tx_h);
    if (m_tx_h) chk(req, "tx_win_idx", tx_win_idx, m_tx_i);
    chk(req, "rx_win_en", rx_win_en, m_rx_h);
    if (m_rx_h) chk(req, "rx_win_idx", rx_win_idx, m_rx_i);
    chk(req, "fifo_win_en", fifo_win_en, m_ff_h);
    chk(req, "fifo_win_idx", fifo_win_idx, 8 + m_ptr);
    chk(req, "lock_err", lock_err, m_err);
    chk(req, "commit_pend", commit_pend, m_cp);
  endtask

  task automatic slot_model(inout bit h, inout int hi, input int idx, inout bit ne);
    if (h) begin
      if (hi == idx) h = 0; else ne = 1;
    end else if (pe_busy[idx]) ne = 1;
    else begin h = 1; hi = idx; end
  endtask

  task automatic wr(int idx, bit lk, bit cm, bit clr);
    bit ne = 0;
    @(negedge clk);
    host_wr = 1; host_idx = 4'(idx); host_lock = lk; host_commit = cm; host_err_clr = clr;
    if (lk) begin
      if (bad_idx(idx)) ne = 1;
      else if (idx < 4) slot_model(m_tx_h, m_tx_i, idx, ne);
      else if (idx < 8) slot_model(m_rx_h, m_rx_i, idx, ne);
      else if (m_ff_h) begin m_ff_h = 0; m_ptr = (m_ptr + 1) % 4; end
      else if (pe_busy[8 + m_ptr]) ne = 1;
      else m_ff_h = 1;
    end
    if (cm && idx < 3) m_cp[idx] = 1;
    if (ne) m_err = 1; else if (clr) m_err = 0;
    @(negedge clk);
    host_wr = 0; host_lock = 0; host_commit = 0; host_err_clr = 0;
  endtask

  task automatic rd(string req, int idx);
    @(negedge clk);
    rd_idx = 4'(idx);
    @(negedge clk);
    chk(req, "rd_locked", rd_locked, m_locked(idx));
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_state("R1");
    rd("R1", 8);

    // sweep every index: lock attempt, readback, second write, clear error
    for (int i = 0; i < 16; i++) begin
      wr(i, 1, 0, 0);
      check_state(bad_idx(i) ? "R7" : (i >= 8 ? "R6" : "R2"));
      rd(bad_idx(i) ? "R7" : "R2", i);
      wr(i, 1, 0, 0);
      check_state(bad_idx(i) ? "R7" : "R5");
      if (m_err) begin
        wr(0, 0, 0, 1);
        check_state("R9");
      end
    end

    // full FIFO wrap: pointer returns after depth releases
    for (int k = 0; k < 4; k++) begin
      wr(10, 1, 0, 0); check_state("R6");
      rd("R6", 8 + m_ptr);
      wr(9, 1, 0, 0);  check_state("R6");
    end

    // three classes together, then a second lock in each class
    wr(1, 1, 0, 0); wr(5, 1, 0, 0); wr(9, 1, 0, 0);
    check_state("R4");
    rd("R4", 1); rd("R4", 5);
    wr(2, 1, 0, 0); check_state("R3");
    rd("R3", 2);
    wr(6, 1, 0, 0); check_state("R3");
    wr(1, 0, 0, 0); check_state("R11");
    wr(5, 0, 1, 0); check_state("R11");
    wr(4, 0, 0, 1); check_state("R9");
    wr(3, 1, 0, 1); check_state("R9");
    wr(0, 0, 0, 1); check_state("R9");
    wr(1, 1, 0, 0); wr(5, 1, 0, 0); wr(9, 1, 0, 0);
    check_state("R5");

    // busy targets refuse, then succeed once idle
    pe_busy = 12'h020 | (12'h100 << m_ptr);
    wr(5, 1, 0, 0);  check_state("R8");
    wr(0, 0, 0, 1);
    wr(11, 1, 0, 0); check_state("R8");
    wr(0, 0, 0, 1);
    pe_busy = '0;
    wr(5, 1, 0, 0);  check_state("R8");
    wr(11, 1, 0, 0); check_state("R8");
    wr(5, 1, 0, 0);  wr(8, 1, 0, 0);

    // commit sweep
    for (int i = 0; i < 16; i++) begin
      wr(i, 0, 1, 0); check_state("R10");
    end
    for (int k = 0; k < 3; k++) begin
      wr(0, 1, 0, 0); wr(0, 1, 0, 0); check_state("R10");
    end
    @(negedge clk); pe_sent = 4'b0010;
    @(negedge clk); pe_sent = '0; m_cp[1] = 0;
    check_state("R10");
    @(negedge clk);
    pe_sent = 4'b0101; host_wr = 1; host_idx = 0; host_commit = 1;
    @(negedge clk);
    pe_sent = '0; host_wr = 0; host_commit = 0; m_cp[2] = 0;
    check_state("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule